// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block sits on the host side of an eight-channel, double-buffered, 13-bit digital-to-analog converter that is loaded over a parallel bus. It takes one command at a time through a valid/ready handshake and turns it into a correctly timed sequence of bus strobes. The strobes are active-low chip-select, write, four per-pair load strobes and a clear line, along with a 3-bit channel address and a 13-bit data word.

There are four command kinds:

- **Write** loads one channel's input latch.
- **Write-with-load** also opens the DAC latch of that channel's pair. The pair's load strobe falls together with the write strobe and is held low for a full load pulse after the write strobe has risen.
- **Update** pulses any subset of the four pair load strobes together, so several outputs change at the same time.
- **Clear** pulses the clear line on its own.

A write may mark its value as two's complement. In that case the value is converted to the converter's offset-binary code before it is driven.

Every minimum time on the bus is a nanosecond parameter. The block turns each one into a clock-cycle count by rounding up at the configured clock period, with a floor of one cycle. A busy output is high for the whole length of a sequence.

Top module: `dacbus_seq`

## Requirements
- R1: After reset and whenever no sequence runs, `busy` is 0, `cmd_ready` is 1, and `cs_n`, `wr_n`, `clr_n` and every bit of `ld_n` are 1.
- R2: A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 (and `busy` is 1) from that edge until the sequence ends, so only one command runs at a time.
- R3: The `cmd_op` encoding is 2'b00 write, 2'b01 write-with-load, 2'b10 update and 2'b11 clear.
  - For a write, `addr` carries `cmd_chan`.
  - `cs_n` and `wr_n` fall on the same edge and rise on the same edge.
  - They stay low for exactly WCYC cycles. WCYC is the largest of the cycle counts for the 50 ns strobe width, the 20 ns data setup and the 10 ns address setup.
- R4: `addr` and `data` are driven one cycle before `cs_n`/`wr_n` fall. They do not change while `cs_n` is low, and they are still unchanged in the cycle after the strobes rise.
- R5: The data word has been stable for at least the data-setup cycle count, and the address for at least the address-setup cycle count, when `wr_n` rises.
- R6: When `cmd_twos` is 1, the driven word is the value plus 4096 modulo 8192, which is `cmd_data` with bit 12 inverted. When `cmd_twos` is 0, `cmd_data` is driven unchanged.
- R7: An update drives `ld_n[i]` low for exactly LCYC cycles (the 50 ns load width) for each set bit i of `cmd_mask`, with all selected strobes in the same cycles. Pair i covers channels 2i and 2i+1. A mask of zero produces no strobe.
- R8: A write-with-load drives `ld_n[cmd_chan >> 1]` low on the same edge that `cs_n`/`wr_n` fall. That strobe stays low for exactly LCYC cycles after `wr_n` rises, and no other load strobe moves.
- R9: A clear drives `clr_n` low for exactly CCYC cycles (the 100 ns width), with `cs_n`, `wr_n` and all `ld_n` high. A command presented during the clear is not taken and causes no strobe until `clr_n` has risen.
- R10: Each cycle count is the nanosecond parameter divided by `CLK_NS` and rounded up, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | Command kind (see R3) |
| cmd_chan | input | CH_W | Target channel for writes |
| cmd_data | input | DATA_W | Value for writes |
| cmd_twos | input | 1 | Value is two's complement |
| cmd_mask | input | 2**CH_W/2 | Pair mask for updates |
| busy | output | 1 | A sequence is running |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr | output | CH_W | Channel address bus |
| data | output | DATA_W | Data bus |
| ld_n | output | 2**CH_W/2 | Per-pair load strobes, active low |
| clr_n | output | 1 | Clear strobe, active low |

## Verification
The bench builds the block with its default parameters: an 8 ns clock with the 50, 20, 10 and 100 ns minimums. These give a 7-cycle write pulse, 7-cycle load pulse and tail, and a 13-cycle clear. The write pulse, rather than the 3-cycle data setup or 2-cycle address setup, sets WCYC, so the setup-age checks carry real margin.

With only eight channels and four pairs, the bench can cover nearly every case:

- Every channel is written with boundary and ordinary codes, in both code formats.
- All sixteen update masks are run.
- Write-with-load is run on every channel.
- A write is held against a running clear.

Expected codes and pulse widths are computed arithmetically in the bench.

// File: rtl/dacbus_pkg.sv
// Package: shared command and state encodings for the DAC bus sequencer,
// plus the nanosecond-to-cycle conversion used to size every bus phase.
package dacbus_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_WRLOAD = 2'b01,
        OP_UPDATE = 2'b10,
        OP_CLEAR  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TAIL,
        ST_UPD,
        ST_CLR
    } st_e;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dacbus_timer.sv
// Module: dacbus_timer
// Down-counter that times each bus phase. A load presets the count. It then
// decrements to zero and stays there. Assumes the controller loads N-1 for
// an N-cycle phase and moves on in the cycle where `zero` is high.
module dacbus_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Preset on load, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // Without a new preset the count must not wrap below zero (phase lengths, R3).
    assert_timer_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/dacbus_conv.sv
// Module: dacbus_conv
// Purely combinational decode of one incoming command. It converts a
// two's-complement value to offset binary by inverting the top bit, and it
// turns the channel number into a one-hot mask of its converter pair.
// Assumes channels 2i and 2i+1 share pair i.
module dacbus_conv #(
    parameter int CH_W   = 3,
    parameter int DATA_W = 13,
    parameter int PAIRS  = 4
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              twos,
    input  logic [CH_W-1:0]   chan,
    output logic [DATA_W-1:0] code,
    output logic [PAIRS-1:0]  pair_sel
);

    localparam int PAIR_W = (CH_W > 1) ? CH_W - 1 : 1;

    logic [PAIR_W-1:0] pair_idx;

    // Adding half scale modulo full scale is a flip of the sign bit.
    always_comb begin
        code = raw;
        code[DATA_W-1] = raw[DATA_W-1] ^ twos;
    end

    assign pair_idx = PAIR_W'(chan >> 1);

    // One compare per pair gives the one-hot pair select.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_sel[p] = (pair_idx == PAIR_W'(p));
    end

endmodule

// File: rtl/dacbus_fsm.sv
// Module: dacbus_fsm
// Sequences each command onto the bus through registered strobe outputs.
// A write drives address and data, waits one cycle, holds chip select and
// write low together for WCYC cycles, then keeps address and data for one
// more cycle. A write-with-load also holds its pair strobe for LCYC cycles
// after write rises. An update pulses the masked pair strobes, and a clear
// pulses the clear line alone. Assumes the timer preset follows `tmr_load`.
module dacbus_fsm
    import dacbus_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DATA_W = 13,
    parameter int PAIRS  = 4,
    parameter int CNT_W  = 4,
    parameter int W_CYC  = 7,
    parameter int L_CYC  = 7,
    parameter int C_CYC  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CH_W-1:0]   cmd_chan,
    input  logic [DATA_W-1:0] code,
    input  logic [PAIRS-1:0]  pair_sel,
    input  logic [PAIRS-1:0]  cmd_mask,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cmd_ready,
    output logic              busy,
    output logic              cs_n,
    output logic              wr_n,
    output logic [CH_W-1:0]   addr,
    output logic [DATA_W-1:0] data,
    output logic [PAIRS-1:0]  ld_n,
    output logic              clr_n
);

    localparam logic [CNT_W-1:0] W_PRE = CNT_W'(W_CYC - 1);
    localparam logic [CNT_W-1:0] L_PRE = CNT_W'(L_CYC - 1);
    localparam logic [CNT_W-1:0] C_PRE = CNT_W'(C_CYC - 1);

    st_e              state;
    op_e              op_q;
    logic [PAIRS-1:0] pair_q;
    op_e              op_in;

    assign op_in     = op_e'(cmd_op);
    assign cmd_ready = (state == ST_IDLE);
    assign busy      = !cmd_ready;

    // Choose when and with what the phase timer is preset.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && op_in == OP_UPDATE) begin
                    tmr_load = 1'b1;
                    tmr_val  = L_PRE;
                end else if (cmd_valid && op_in == OP_CLEAR) begin
                    tmr_load = 1'b1;
                    tmr_val  = C_PRE;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = W_PRE;
            end
            ST_STROBE: begin
                if (tmr_zero && op_q == OP_WRLOAD) begin
                    tmr_load = 1'b1;
                    tmr_val  = L_PRE;
                end
            end
            default: ;
        endcase
    end

    // Step the sequence and update the registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_WRITE;
            pair_q <= '0;
            cs_n   <= 1'b1;
            wr_n   <= 1'b1;
            ld_n   <= '1;
            clr_n  <= 1'b1;
            addr   <= '0;
            data   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q <= op_in;
                        unique case (op_in)
                            OP_WRITE, OP_WRLOAD: begin
                                addr   <= cmd_chan;
                                data   <= code;
                                pair_q <= pair_sel;
                                state  <= ST_SETUP;
                            end
                            OP_UPDATE: begin
                                ld_n  <= ~cmd_mask;
                                state <= ST_UPD;
                            end
                            default: begin
                                clr_n <= 1'b0;
                                state <= ST_CLR;
                            end
                        endcase
                    end
                end
                ST_SETUP: begin
                    cs_n <= 1'b0;
                    wr_n <= 1'b0;
                    if (op_q == OP_WRLOAD)
                        ld_n <= ~pair_q;
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (tmr_zero) begin
                        cs_n  <= 1'b1;
                        wr_n  <= 1'b1;
                        state <= (op_q == OP_WRLOAD) ? ST_TAIL : ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    state <= ST_IDLE;
                end
                ST_TAIL: begin
                    if (tmr_zero) begin
                        ld_n  <= '1;
                        state <= ST_IDLE;
                    end
                end
                ST_UPD: begin
                    if (tmr_zero) begin
                        ld_n  <= '1;
                        state <= ST_IDLE;
                    end
                end
                ST_CLR: begin
                    if (tmr_zero) begin
                        clr_n <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Idle means every strobe is released.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (cs_n && wr_n && clr_n && (&ld_n)));

    // Ready only drops because a command was offered.
    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_ready) |-> $past(cmd_valid));

    // Address and data hold still while chip select stays low.
    assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(data)));

    // A load strobe that overlaps the write outlives the write strobe.
    assert_load_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n) && !(&$past(ld_n))) |-> !(&ld_n));

    // The clear pulse runs with every other strobe released.
    assert_clear_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (cs_n && wr_n && (&ld_n)));

endmodule

// File: rtl/dacbus_seq.sv
// Module: dacbus_seq (top)
// Host-side sequencer for the parallel bus of an octal double-buffered DAC.
// Turns the nanosecond minimums into cycle counts, decodes each command and
// runs it through the strobe state machine. Assumes the bus is not shared
// and that CLK_NS is the true clock period.
module dacbus_seq
    import dacbus_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int CH_W      = 3,
    parameter int DATA_W    = 13,
    parameter int T_CSWR_NS = 50,
    parameter int T_LD_NS   = 50,
    parameter int T_CLR_NS  = 100,
    parameter int T_DSU_NS  = 20,
    parameter int T_ASU_NS  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_op,
    input  logic [CH_W-1:0]          cmd_chan,
    input  logic [DATA_W-1:0]        cmd_data,
    input  logic                     cmd_twos,
    input  logic [2**CH_W/2-1:0]     cmd_mask,
    output logic                     busy,
    output logic                     cs_n,
    output logic                     wr_n,
    output logic [CH_W-1:0]          addr,
    output logic [DATA_W-1:0]        data,
    output logic [2**CH_W/2-1:0]     ld_n,
    output logic                     clr_n
);

    localparam int PAIRS = 2**CH_W / 2;
    localparam int W_CYC = max3(ns_to_cyc(T_CSWR_NS, CLK_NS),
                                ns_to_cyc(T_DSU_NS, CLK_NS),
                                ns_to_cyc(T_ASU_NS, CLK_NS));
    localparam int L_CYC = ns_to_cyc(T_LD_NS, CLK_NS);
    localparam int C_CYC = ns_to_cyc(T_CLR_NS, CLK_NS);
    localparam int CNT_W = $clog2(max3(W_CYC, L_CYC, C_CYC) + 1);

    logic [DATA_W-1:0] code;
    logic [PAIRS-1:0]  pair_sel;
    logic              tmr_load;
    logic              tmr_zero;
    logic [CNT_W-1:0]  tmr_val;

    dacbus_conv #(
        .CH_W   (CH_W),
        .DATA_W (DATA_W),
        .PAIRS  (PAIRS)
    ) u_conv (
        .raw      (cmd_data),
        .twos     (cmd_twos),
        .chan     (cmd_chan),
        .code     (code),
        .pair_sel (pair_sel)
    );

    dacbus_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dacbus_fsm #(
        .CH_W   (CH_W),
        .DATA_W (DATA_W),
        .PAIRS  (PAIRS),
        .CNT_W  (CNT_W),
        .W_CYC  (W_CYC),
        .L_CYC  (L_CYC),
        .C_CYC  (C_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_chan  (cmd_chan),
        .code      (code),
        .pair_sel  (pair_sel),
        .cmd_mask  (cmd_mask),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .cmd_ready (cmd_ready),
        .busy      (busy),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .data      (data),
        .ld_n      (ld_n),
        .clr_n     (clr_n)
    );

endmodule

// File: tb/sim_dacbus_seq.sv
// Bench for dacbus_seq: drives channel, code and mask sweeps. A bus monitor
// measures pulse widths and stability each cycle at the falling clock edge.
module sim_dacbus_seq;

    localparam int CLK_NS = 8;
    localparam int EXP_W  = 7;   // max(ceil(50/8), ceil(20/8), ceil(10/8))
    localparam int EXP_L  = 7;   // ceil(50/8)
    localparam int EXP_C  = 13;  // ceil(100/8)
    localparam int DSU    = 3;   // ceil(20/8)
    localparam int ASU    = 2;   // ceil(10/8)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b00;
    logic [2:0]  cmd_chan = '0;
    logic [12:0] cmd_data = '0;
    logic        cmd_twos = 1'b0;
    logic [3:0]  cmd_mask = '0;
    logic        busy, cs_n, wr_n, clr_n;
    logic [2:0]  addr;
    logic [12:0] data;
    logic [3:0]  ld_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dacbus_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_chan  (cmd_chan),
        .cmd_data  (cmd_data),
        .cmd_twos  (cmd_twos),
        .cmd_mask  (cmd_mask),
        .busy      (busy),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .data      (data),
        .ld_n      (ld_n),
        .clr_n     (clr_n)
    );

    // Monitor state
    logic        prev_cs = 1'b1, prev_clr = 1'b1;
    logic [3:0]  prev_ld = 4'hF, ld_at_rise = 4'hF;
    logic [2:0]  prev_addr = '0, cs_addr = '0;
    logic [12:0] prev_data = '0, cs_data = '0;
    int age = 0, prev_age = 0, cs_age = 0;
    int cs_cnt = 0, cs_w = 0, cs_pulses = 0;
    int tail_cnt = 0, tail_w = 0;
    int clr_cnt = 0, clr_w = 0, clr_pulses = 0;
    int ld_cnt [4] = '{0, 0, 0, 0};
    int ld_w [4] = '{0, 0, 0, 0};
    int ld_pulses [4] = '{0, 0, 0, 0};
    int stab_err = 0, sync_err = 0, idle_err = 0, rdy_err = 0, alone_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n !== wr_n) sync_err++;
            if (cmd_ready === busy) rdy_err++;
            if (!busy && (cs_n !== 1'b1 || ld_n !== 4'hF || clr_n !== 1'b1)) idle_err++;
            if (clr_n === 1'b0 && (cs_n !== 1'b1 || ld_n !== 4'hF)) alone_err++;
            if (addr !== prev_addr || data !== prev_data) age = 0;
            else age++;
            if (cs_n === 1'b0) begin
                if (!prev_cs && (addr !== prev_addr || data !== prev_data)) stab_err++;
                cs_cnt++;
                tail_cnt = 0;
            end else if (!prev_cs) begin
                cs_w = cs_cnt;
                cs_addr = prev_addr;
                cs_data = prev_data;
                cs_age = prev_age;
                ld_at_rise = prev_ld;
                cs_cnt = 0;
                cs_pulses++;
                if (addr !== prev_addr || data !== prev_data) stab_err++;
            end
            if (cs_n === 1'b1 && ld_n !== 4'hF) tail_cnt++;
            for (int p = 0; p < 4; p++) begin
                if (ld_n[p] === 1'b0) ld_cnt[p]++;
                else if (!prev_ld[p]) begin
                    ld_w[p] = ld_cnt[p];
                    ld_cnt[p] = 0;
                    ld_pulses[p]++;
                    tail_w = tail_cnt;
                end
            end
            if (clr_n === 1'b0) clr_cnt++;
            else if (!prev_clr) begin
                clr_w = clr_cnt;
                clr_cnt = 0;
                clr_pulses++;
            end
            prev_cs = cs_n;
            prev_clr = clr_n;
            prev_ld = ld_n;
            prev_addr = addr;
            prev_data = data;
            prev_age = age;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Present a command, hold it until taken, then wait for the sequence end.
    task automatic run_cmd(input logic [1:0] op, input logic [2:0] ch,
                           input logic [12:0] v, input logic tw, input logic [3:0] m);
        @(negedge clk);
        cmd_op = op; cmd_chan = ch; cmd_data = v; cmd_twos = tw; cmd_mask = m;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    function automatic int exp_code(input int v, input bit tw);
        return tw ? ((v + 4096) % 8192) : v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int vals [7];
        int pulses_before [4];
        int csb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check(busy === 1'b0 && cmd_ready === 1'b1, "R1 ready after reset", busy, 0);
        check(cs_n === 1'b1 && wr_n === 1'b1 && clr_n === 1'b1 && ld_n === 4'hF,
              "R1 strobes high after reset", {cs_n, wr_n, clr_n, ld_n}, 7'h7F);

        // R3 R4 R5 R6 R10: channel and code sweep in both formats
        vals = '{0, 1, 4095, 4096, 4097, 8191, 0};
        for (int ch = 0; ch < 8; ch++) begin
            vals[6] = (ch * 1000 + 7) % 8192;
            for (int vi = 0; vi < 7; vi++) begin
                for (int tw = 0; tw < 2; tw++) begin
                    csb = cs_pulses;
                    run_cmd(2'b00, 3'(ch), 13'(vals[vi]), tw[0], 4'h0);
                    check(cs_pulses == csb + 1, "R3 one write pulse", cs_pulses - csb, 1);
                    check(cs_addr == 3'(ch), "R3 address", cs_addr, ch);
                    check(cs_data == 13'(exp_code(vals[vi], tw[0])), "R6 code conversion",
                          cs_data, exp_code(vals[vi], tw[0]));
                    check(cs_w == EXP_W, "R10 R3 write width", cs_w, EXP_W);
                    check(cs_age >= DSU && cs_age >= ASU, "R5 setup age", cs_age, DSU);
                end
            end
        end

        // R7: every update mask
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 4; p++) pulses_before[p] = ld_pulses[p];
            run_cmd(2'b10, 3'd0, 13'd0, 1'b0, 4'(m));
            for (int p = 0; p < 4; p++) begin
                check(ld_pulses[p] - pulses_before[p] == ((m >> p) & 1), "R7 pair strobe count",
                      ld_pulses[p] - pulses_before[p], (m >> p) & 1);
                if ((m >> p) & 1)
                    check(ld_w[p] == EXP_L, "R7 load width", ld_w[p], EXP_L);
            end
        end

        // R8: write-with-load on every channel
        for (int ch = 0; ch < 8; ch++) begin
            for (int p = 0; p < 4; p++) pulses_before[p] = ld_pulses[p];
            run_cmd(2'b01, 3'(ch), 13'(ch * 3 + 100), 1'b1, 4'h0);
            check(cs_data == 13'(exp_code(ch * 3 + 100, 1'b1)), "R8 R6 data", cs_data,
                  exp_code(ch * 3 + 100, 1'b1));
            check(cs_addr == 3'(ch), "R8 address", cs_addr, ch);
            check(ld_at_rise == ~(4'b1 << (ch >> 1)), "R8 strobe low at write rise",
                  ld_at_rise, ~(4'b1 << (ch >> 1)) & 4'hF);
            check(tail_w == EXP_L, "R8 tail length", tail_w, EXP_L);
            check(ld_w[ch >> 1] == EXP_W + EXP_L, "R8 load width", ld_w[ch >> 1], EXP_W + EXP_L);
            for (int p = 0; p < 4; p++)
                check(ld_pulses[p] - pulses_before[p] == ((p == (ch >> 1)) ? 1 : 0),
                      "R8 only own pair", ld_pulses[p] - pulses_before[p], (p == (ch >> 1)) ? 1 : 0);
        end

        // R9: clear, with a write held against it
        @(negedge clk);
        cmd_op = 2'b11; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_op = 2'b00; cmd_chan = 3'd5; cmd_data = 13'd1234; cmd_twos = 1'b0;
        csb = cs_pulses;
        while (clr_n === 1'b0) @(negedge clk);
        #1;
        check(cs_pulses == csb && cs_n === 1'b1, "R9 write held off during clear",
              cs_pulses - csb, 0);
        check(clr_w == EXP_C, "R9 clear width", clr_w, EXP_C);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        #1;
        check(cs_pulses == csb + 1 && cs_data == 13'd1234 && cs_addr == 3'd5,
              "R2 pending write runs after clear", cs_data, 1234);
        run_cmd(2'b11, 3'd0, 13'd0, 1'b0, 4'h0);
        check(clr_w == EXP_C && clr_pulses == 2, "R9 second clear", clr_w, EXP_C);

        check(stab_err == 0, "R4 address/data stable", stab_err, 0);
        check(sync_err == 0, "R3 cs/wr together", sync_err, 0);
        check(idle_err == 0, "R1 idle strobes high", idle_err, 0);
        check(rdy_err == 0, "R2 ready is not busy", rdy_err, 0);
        check(alone_err == 0, "R9 clear alone", alone_err, 0);
        check(busy === 1'b0 && cmd_ready === 1'b1, "R1 idle at end", busy, 0);
        finish_run();
    end

endmodule